// File: doc/BRIEF.md
# Low-Frequency Timer and Watchdog Cluster

This block groups three timers that live on a slow 32.768 kHz reference: a time-of-day counter with an alarm, a periodic interrupt timer and a watchdog. A single free-running prescaler divides the reference. Each timer takes a strobe from a fixed tap of that prescaler, so the three never drift against each other, and the block holds only one divider counter. Everything runs in one clock domain. A `ref_tick` enable marks each reference period.

The time of day is kept as a 32-bit seconds count plus a fraction that counts 1/256 of a second, because 32768 / 128 gives 256 steps per second. Software uses a small word-wide register port to do the following:

- set and read the time and the alarm;
- pick the timer mode and set its modulus;
- arm the watchdog with a 6-bit timeout and feed it with a two-word key sequence.

The block has three outputs: `alarm_irq`, `pit_irq` and `wdg_rst_req`.

Register map (`addr`): 0 seconds, 1 fraction, 2 alarm seconds, 3 alarm fraction, 4 alarm control, 5 timer control, 6 timer modulus, 7 timer count (read only), 8 watchdog control, 9 watchdog key (a write feeds the key, a read returns the watchdog count in bits 5:0).

Top module: `lf_timer_top`

## Requirements
- R1: The prescaler advances only on cycles with `ref_tick` high. The time of day steps once every 128 ticks and the periodic timer steps once every 4 ticks. The watchdog steps once every 2**WDG_DIV_LOG ticks, which is 16384 by default.
- R2: The fraction is 8 bits wide and reads as zero in bits 31:8. On a step from 255 it wraps to 0, and the seconds word gains one on the same step.
- R3: Addresses 0 and 1 can be written and read back. A write takes priority over a step in the same cycle.
- R4: The alarm pending flag (address 4, bit 8) sets when a time-of-day step produces seconds and a fraction equal to the alarm words at addresses 2 and 3. Writing 1 to bit 8 clears it. `alarm_irq` is high while the flag and the enable bit (address 4, bit 0) are both high.
- R5: With control bit 1 at 0 (reload mode), the periodic count goes down by one per step. A step at 0 reloads the modulus and sets the flag. A write to address 6 sets the modulus and loads the count. Steps happen only while bit 0 (run) is set.
- R6: With control bit 1 at 1 (free mode), a step at 0 wraps the count to all ones and sets the flag.
- R7: The timer flag can be read in bit 8 of address 5 for polling, and writing 1 to bit 8 clears it. `pit_irq` follows the flag while bit 2 (interrupt enable) is set.
- R8: A write to address 8 loads the timeout from bits 5:0 and the enable from bit 8, and it loads the count with the timeout. While enabled, each watchdog step lowers the count. A step at a count of 1 or 0 raises `wdg_rst_req` and reloads the timeout.
- R9: `wdg_rst_req` stays high until the next `ref_tick` that does not fire again.
- R10: Writing 16'h5555 and then 16'hAAAA to address 9 reloads the watchdog count with the timeout. Any other write in between, to any address, restarts the sequence.
- R11: After reset, every register reads zero and all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle enable per reference period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| alarm_irq | output | 1 | Alarm interrupt |
| pit_irq | output | 1 | Periodic timer interrupt |
| wdg_rst_req | output | 1 | Watchdog reset request |

## Verification
The periodic timer is driven from a table of modulus, mode and tick counts. The entries fall before, at and after a reload or wrap, and include a modulus of zero, so the table separates reload mode from free mode and shows whether the flag sets on the right step. The time of day is tried with a plain step, a fraction write with junk in the high bits and a 255 wrap, which separates the fraction-to-seconds carry from a simple increment. The watchdog is run three ways: with no service, with a correct key pair, and with a key pair split by a foreign write. These show expiry timing, the reload and the sequence restart. A stretch with the tick held low shows that nothing moves without the reference enable.

// File: rtl/lf_timer_pkg.sv
package lf_timer_pkg;

    typedef enum logic [3:0] {
        A_SEC      = 4'd0,
        A_FRAC     = 4'd1,
        A_ALM_SEC  = 4'd2,
        A_ALM_FRAC = 4'd3,
        A_ALM_CTL  = 4'd4,
        A_PIT_CTL  = 4'd5,
        A_PIT_MOD  = 4'd6,
        A_PIT_CNT  = 4'd7,
        A_WDG_CTL  = 4'd8,
        A_WDG_KEY  = 4'd9
    } reg_addr_e;

    localparam logic [15:0] WDG_KEY_FIRST  = 16'h5555;
    localparam logic [15:0] WDG_KEY_SECOND = 16'hAAAA;

    typedef struct packed {
        logic tod;
        logic pit;
        logic wdg;
    } tap_strobe_t;

    typedef struct packed {
        logic ie;
        logic free;
        logic run;
    } pit_cfg_t;

    function automatic logic tap_hit(input logic [31:0] cnt, input int unsigned lg);
        logic [31:0] m;
        m = (32'd1 << lg) - 32'd1;
        return (cnt & m) == m;
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned r;
        r = (a > b) ? a : b;
        return (r > c) ? r : c;
    endfunction

endpackage

// File: rtl/lf_prescaler.sv
module lf_prescaler
    import lf_timer_pkg::*;
#(
    parameter int unsigned TOD_DIV_LOG = 7,
    parameter int unsigned PIT_DIV_LOG = 2,
    parameter int unsigned WDG_DIV_LOG = 14
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ref_tick,
    output tap_strobe_t stb
);
    localparam int unsigned PRE_W = max3(TOD_DIV_LOG, PIT_DIV_LOG, WDG_DIV_LOG);

    logic [PRE_W-1:0] pcnt;

    always_ff @(posedge clk) begin
        if (rst)           pcnt <= '0;
        else if (ref_tick) pcnt <= pcnt + 1'b1;
    end

    always_comb begin
        stb.tod = ref_tick && tap_hit(32'(pcnt), TOD_DIV_LOG);
        stb.pit = ref_tick && tap_hit(32'(pcnt), PIT_DIV_LOG);
        stb.wdg = ref_tick && tap_hit(32'(pcnt), WDG_DIV_LOG);
    end
endmodule

// File: rtl/lf_tod.sv
module lf_tod (
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    input  logic        wr_sec,
    input  logic        wr_frac,
    input  logic        wr_asec,
    input  logic        wr_afrac,
    input  logic        wr_actl,
    input  logic [31:0] wdata,
    output logic [31:0] sec,
    output logic [7:0]  frac,
    output logic [31:0] asec,
    output logic [7:0]  afrac,
    output logic        alm_en,
    output logic        alm_pend
);
    logic [7:0]  frac_nx;
    logic [31:0] sec_nx;
    logic        hit;

    always_comb begin
        frac_nx = frac + 8'd1;
        sec_nx  = sec + {31'd0, (frac == 8'hFF)};
        hit     = step && !wr_sec && !wr_frac && (sec_nx == asec) && (frac_nx == afrac);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec      <= '0;
            frac     <= '0;
            asec     <= '0;
            afrac    <= '0;
            alm_en   <= 1'b0;
            alm_pend <= 1'b0;
        end else begin
            if (wr_sec)    sec  <= wdata;
            else if (step) sec  <= sec_nx;
            if (wr_frac)   frac <= wdata[7:0];
            else if (step) frac <= frac_nx;
            if (wr_asec)  asec   <= wdata;
            if (wr_afrac) afrac  <= wdata[7:0];
            if (wr_actl)  alm_en <= wdata[0];
            if (hit)                      alm_pend <= 1'b1;
            else if (wr_actl && wdata[8]) alm_pend <= 1'b0;
        end
    end
endmodule

// File: rtl/lf_pit.sv
module lf_pit
    import lf_timer_pkg::*;
#(
    parameter int unsigned PIT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             wr_ctl,
    input  logic             wr_mod,
    input  logic [31:0]      wdata,
    output pit_cfg_t         cfg,
    output logic [PIT_W-1:0] modulus,
    output logic [PIT_W-1:0] cnt,
    output logic             flag
);
    logic at_zero;
    logic fire;

    always_comb begin
        at_zero = (cnt == '0);
        fire    = step && cfg.run && !wr_mod && at_zero;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            modulus <= '0;
            cnt     <= '0;
            flag    <= 1'b0;
        end else begin
            if (wr_ctl) cfg <= pit_cfg_t'(wdata[2:0]);
            if (wr_mod) begin
                modulus <= wdata[PIT_W-1:0];
                cnt     <= wdata[PIT_W-1:0];
            end else if (step && cfg.run) begin
                if (at_zero) cnt <= cfg.free ? '1 : modulus;
                else         cnt <= cnt - 1'b1;
            end
            if (fire)                    flag <= 1'b1;
            else if (wr_ctl && wdata[8]) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/lf_wdog.sv
module lf_wdog
    import lf_timer_pkg::*;
#(
    parameter int unsigned WDG_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic             step,
    input  logic             wr_ctl,
    input  logic             wr_key,
    input  logic             wr_other,
    input  logic [31:0]      wdata,
    output logic             en,
    output logic [WDG_W-1:0] timeout,
    output logic [WDG_W-1:0] cnt,
    output logic             rst_req
);
    logic armed;
    logic service;
    logic fire;

    always_comb begin
        service = wr_key && armed && (wdata[15:0] == WDG_KEY_SECOND);
        fire    = step && en && !wr_ctl && !service && (cnt <= WDG_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en      <= 1'b0;
            timeout <= '0;
            cnt     <= '0;
            armed   <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            if (wr_ctl) begin
                timeout <= wdata[WDG_W-1:0];
                en      <= wdata[8];
                cnt     <= wdata[WDG_W-1:0];
            end else if (service) begin
                cnt <= timeout;
            end else if (step && en) begin
                if (cnt <= WDG_W'(1)) cnt <= timeout;
                else                  cnt <= cnt - 1'b1;
            end
            if (wr_key)        armed <= (wdata[15:0] == WDG_KEY_FIRST);
            else if (wr_other) armed <= 1'b0;
            if (fire)          rst_req <= 1'b1;
            else if (ref_tick) rst_req <= 1'b0;
        end
    end
endmodule

// File: rtl/lf_timer_top.sv
module lf_timer_top
    import lf_timer_pkg::*;
#(
    parameter int unsigned TOD_DIV_LOG = 7,
    parameter int unsigned PIT_DIV_LOG = 2,
    parameter int unsigned WDG_DIV_LOG = 14,
    parameter int unsigned PIT_W       = 16,
    parameter int unsigned WDG_W       = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ref_tick,
    input  logic        wr_en,
    input  logic [3:0]  addr,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        alarm_irq,
    output logic        pit_irq,
    output logic        wdg_rst_req
);
    localparam int unsigned PIT_PAD = 32 - PIT_W;
    localparam int unsigned WDG_PAD = 32 - WDG_W;

    tap_strobe_t      stb;
    logic [31:0]      sec, asec;
    logic [7:0]       frac, afrac;
    logic             alm_en, alm_pend;
    pit_cfg_t         pit_cfg;
    logic [PIT_W-1:0] pit_mod, pit_cnt;
    logic             pit_flag;
    logic             wdg_en;
    logic [WDG_W-1:0] wdg_to, wdg_cnt;

    lf_prescaler #(
        .TOD_DIV_LOG(TOD_DIV_LOG),
        .PIT_DIV_LOG(PIT_DIV_LOG),
        .WDG_DIV_LOG(WDG_DIV_LOG)
    ) u_pre (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .stb(stb)
    );

    lf_tod u_tod (
        .clk(clk), .rst(rst), .step(stb.tod),
        .wr_sec  (wr_en && addr == A_SEC),
        .wr_frac (wr_en && addr == A_FRAC),
        .wr_asec (wr_en && addr == A_ALM_SEC),
        .wr_afrac(wr_en && addr == A_ALM_FRAC),
        .wr_actl (wr_en && addr == A_ALM_CTL),
        .wdata(wr_data),
        .sec(sec), .frac(frac), .asec(asec), .afrac(afrac),
        .alm_en(alm_en), .alm_pend(alm_pend)
    );

    lf_pit #(.PIT_W(PIT_W)) u_pit (
        .clk(clk), .rst(rst), .step(stb.pit),
        .wr_ctl(wr_en && addr == A_PIT_CTL),
        .wr_mod(wr_en && addr == A_PIT_MOD),
        .wdata(wr_data),
        .cfg(pit_cfg), .modulus(pit_mod), .cnt(pit_cnt), .flag(pit_flag)
    );

    lf_wdog #(.WDG_W(WDG_W)) u_wdg (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .step(stb.wdg),
        .wr_ctl  (wr_en && addr == A_WDG_CTL),
        .wr_key  (wr_en && addr == A_WDG_KEY),
        .wr_other(wr_en && addr != A_WDG_KEY),
        .wdata(wr_data),
        .en(wdg_en), .timeout(wdg_to), .cnt(wdg_cnt), .rst_req(wdg_rst_req)
    );

    always_comb begin
        alarm_irq = alm_pend && alm_en;
        pit_irq   = pit_flag && pit_cfg.ie;
        case (addr)
            A_SEC:      rd_data = sec;
            A_FRAC:     rd_data = {24'd0, frac};
            A_ALM_SEC:  rd_data = asec;
            A_ALM_FRAC: rd_data = {24'd0, afrac};
            A_ALM_CTL:  rd_data = {23'd0, alm_pend, 7'd0, alm_en};
            A_PIT_CTL:  rd_data = {23'd0, pit_flag, 5'd0, pit_cfg};
            A_PIT_MOD:  rd_data = {{PIT_PAD{1'b0}}, pit_mod};
            A_PIT_CNT:  rd_data = {{PIT_PAD{1'b0}}, pit_cnt};
            A_WDG_CTL:  rd_data = {23'd0, wdg_en, {(8-WDG_W){1'b0}}, wdg_to};
            A_WDG_KEY:  rd_data = {{WDG_PAD{1'b0}}, wdg_cnt};
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/lf_timer_chk.sv
module lf_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        ref_tick,
    input logic        wr_en,
    input logic        tod_stb,
    input logic        pit_stb,
    input logic        wdg_stb,
    input logic [31:0] sec,
    input logic [7:0]  frac,
    input logic        alm_pend,
    input logic        pit_flag,
    input logic        wdg_rst
);
    // R1
    strobe_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (tod_stb || pit_stb || wdg_stb) |-> ref_tick);

    // R1
    tod_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tod_stb && !wr_en) |=> ($stable(frac) && $stable(sec)));

    // R2
    frac_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tod_stb && !wr_en && frac == 8'hFF) |=> (frac == 8'd0 && sec == $past(sec) + 32'd1));

    // R4
    alarm_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(alm_pend) |-> $past(tod_stb));

    // R5
    pit_flag_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pit_flag) |-> $past(pit_stb));

    // R8
    wdg_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wdg_rst) |-> $past(wdg_stb));

    // R9
    wdg_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (wdg_rst && ref_tick && !wdg_stb) |=> !wdg_rst);
endmodule

bind lf_timer_top lf_timer_chk u_chk (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .wr_en(wr_en),
    .tod_stb(stb.tod), .pit_stb(stb.pit), .wdg_stb(stb.wdg),
    .sec(sec), .frac(frac), .alm_pend(alm_pend), .pit_flag(pit_flag),
    .wdg_rst(wdg_rst_req)
);

// File: tb/sim_lf_timer_top.sv
module sim_lf_timer_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] rd_data;
    logic        alarm_irq, pit_irq, wdg_rst_req;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    lf_timer_top #(.WDG_DIV_LOG(6)) u0 (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .alarm_irq(alarm_irq),
        .pit_irq(pit_irq), .wdg_rst_req(wdg_rst_req)
    );

    // Periodic timer vectors: modulus, free mode, ticks, expected count, expected flag
    localparam int NV = 6;
    localparam int V_MOD  [NV] = '{5, 5, 3, 2, 10, 0};
    localparam int V_FREE [NV] = '{0, 0, 0, 1, 1, 0};
    localparam int V_TICK [NV] = '{8, 24, 28, 16, 12, 4};
    localparam int V_CNT  [NV] = '{3, 5, 0, 32'hFFFE, 7, 0};
    localparam int V_FLAG [NV] = '{0, 1, 1, 1, 0, 1};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ref_tick = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic run_ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            ref_tick = 1'b1;
            repeat (n) @(negedge clk);
            ref_tick = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog timeout actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        do_reset();

        // R11 reset state
        for (int a = 0; a < 10; a++) begin
            do_rd(4'(a), v);
            chk("R11 reset register", v, 32'd0);
        end
        chk("R11 reset outputs", {29'd0, alarm_irq, pit_irq, wdg_rst_req}, 32'd0);

        // R5 R6 R7 table of periodic timer vectors
        for (int i = 0; i < NV; i++) begin
            do_reset();
            do_wr(4'd6, 32'(V_MOD[i]));
            do_wr(4'd5, 32'h5 | (32'(V_FREE[i]) << 1));
            run_ticks(V_TICK[i]);
            do_rd(4'd7, v);
            chk(V_FREE[i] != 0 ? "R6 count" : "R5 count", v, 32'(V_CNT[i]));
            do_rd(4'd5, v);
            chk("R7 polled flag", 32'(v[8]), 32'(V_FLAG[i]));
            chk("R7 pit_irq", 32'(pit_irq), 32'(V_FLAG[i]));
        end
        do_wr(4'd5, 32'h105);
        chk("R7 flag clear", 32'(pit_irq), 32'd0);

        // R1 time-of-day tap and idle hold
        do_reset();
        run_ticks(127);
        do_rd(4'd1, v);
        chk("R1 tod before tap", v, 32'd0);
        run_ticks(1);
        do_rd(4'd1, v);
        chk("R1 tod at tap", v, 32'd1);
        repeat (20) @(negedge clk);
        do_rd(4'd1, v);
        chk("R1 no tick no step", v, 32'd1);

        // R2 R3 fraction width and wrap
        do_reset();
        do_wr(4'd1, 32'hFFFFFF12);
        do_rd(4'd1, v);
        chk("R2 upper fraction bits zero", v, 32'h12);
        do_wr(4'd1, 32'hFF);
        do_wr(4'd0, 32'd7);
        do_rd(4'd0, v);
        chk("R3 seconds readback", v, 32'd7);
        run_ticks(128);
        do_rd(4'd1, v);
        chk("R2 fraction wraps", v, 32'd0);
        do_rd(4'd0, v);
        chk("R2 seconds carry", v, 32'd8);

        // R4 alarm
        do_reset();
        do_wr(4'd3, 32'd2);
        do_wr(4'd4, 32'd1);
        run_ticks(255);
        chk("R4 alarm early", 32'(alarm_irq), 32'd0);
        run_ticks(1);
        chk("R4 alarm match", 32'(alarm_irq), 32'd1);
        do_wr(4'd4, 32'h101);
        chk("R4 alarm cleared", 32'(alarm_irq), 32'd0);

        // R8 R9 expiry with 64-tick watchdog step, timeout 3
        do_reset();
        do_wr(4'd8, 32'h103);
        run_ticks(191);
        chk("R8 no expiry yet", 32'(wdg_rst_req), 32'd0);
        run_ticks(1);
        chk("R8 expiry", 32'(wdg_rst_req), 32'd1);
        repeat (5) @(negedge clk);
        chk("R9 held without tick", 32'(wdg_rst_req), 32'd1);
        run_ticks(1);
        chk("R9 cleared on tick", 32'(wdg_rst_req), 32'd0);

        // R10 good service sequence
        do_reset();
        do_wr(4'd8, 32'h103);
        run_ticks(128);
        do_rd(4'd9, v);
        chk("R8 count down", v, 32'd1);
        do_wr(4'd9, 32'h5555);
        do_wr(4'd9, 32'hAAAA);
        do_rd(4'd9, v);
        chk("R10 service reload", v, 32'd3);
        run_ticks(128);
        chk("R10 no expiry after service", 32'(wdg_rst_req), 32'd0);

        // R10 broken sequence
        do_wr(4'd9, 32'h5555);
        do_wr(4'd2, 32'd0);
        do_wr(4'd9, 32'hAAAA);
        do_rd(4'd9, v);
        chk("R10 broken sequence ignored", v, 32'd1);
        run_ticks(64);
        chk("R10 expiry after broken sequence", 32'(wdg_rst_req), 32'd1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule